// File: doc/BRIEF.md
# SD EDH Check Word Engine

This block watches a parallel 10-bit standard-definition video word stream and keeps two running 16-bit check words per field: one over the active-picture words and one over the full-field words. When the EDH packet slot arrives, it compares the received ancillary packet against its own results and records any mismatch in three sticky error flags. Depending on two control inputs, it then either passes the received packet through untouched or puts a freshly built, correctly formatted packet in its place.

The packet slot marker also marks the field boundary. At the first word of the slot, both running check words are frozen as the values for the field just ended, and the accumulators restart from zero. The whole stream goes through a delay line exactly one packet long, so the decision to replace a packet can be taken after its last word has been seen. That same decision governs every word of that packet on the output.

Top module: `edh_engine`

## Requirements
- R1: A word with `in_active` high and `pkt_slot` low feeds the active-picture accumulator, and a word with `in_field` high and `pkt_slot` low feeds the full-field accumulator. Each step shifts the 10 bits in least significant bit first through a 16-bit register with generator x^16 + x^12 + x^6 + 1: feedback = msb xor data bit, then shift left, then xor 16'h1041 when the feedback is 1.
- R2: On the first word of a packet slot, both accumulators are copied out as the check words for the ended field, and both restart at zero. Words inside the slot never enter either accumulator.
- R3: A generated packet is 11 words long. Words 0 to 2 are 000h, 3FFh, 3FFh. Word 3 is the identifier 1F4h. Word 4 is the count word 205h, which states five user words.
- R4: Each user word carries a byte in bits 7:0. Bit 8 makes the parity of bits 8:0 even, and bit 9 is the inverse of bit 8. User words 0 to 3 hold active check bits 7:0, active 15:8, full-field 7:0 and full-field 15:8. User word 4 holds the per-packet error bits: bit 0 is active mismatch, bit 1 is full-field mismatch, bit 2 is packet fault.
- R5: Word 10 is the checksum. Bits 8:0 are the 9-bit sum of bits 8:0 of words 3 to 9, and bit 9 is the inverse of bit 8. A received packet whose word 10 differs from this value, or whose words 0 to 4 differ from R3, has a packet fault.
- R6: Outside replaced packets, `vid_out` shows the word sampled from `vid_in` ten clock cycles earlier, bit for bit.
- R7: If `edh_force` is high when the last packet word is sampled, the whole packet is replaced by a generated one.
- R8: If only `edh_en` is high at that moment, the packet is replaced only when some error bit of R4 is set. A fully correct packet passes through unchanged.
- R9: With both controls low, the packet passes through unchanged, and the error flags still update.
- R10: `err_ap`, `err_ff` and `err_pkt` are set by the error bits of each packet one cycle after its last word is sampled. They stay set until `err_clr` is sampled high. A new error in the same cycle as `err_clr` leaves its flag set.
- R11: Reset clears the flags, the delay line and both accumulators and check words. A packet right after reset therefore carries user words 0 to 3 equal to 200h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| vid_in | input | 10 | Incoming video word |
| in_active | input | 1 | Word lies in the active picture |
| in_field | input | 1 | Word lies in the full-field check range |
| pkt_slot | input | 1 | Word lies in the 11-word EDH packet slot |
| edh_en | input | 1 | Replace the packet when it is wrong or missing |
| edh_force | input | 1 | Always replace the packet |
| err_clr | input | 1 | Clears the sticky error flags |
| vid_out | output | 10 | Delayed video with the packet possibly replaced |
| err_ap | output | 1 | Sticky active-picture mismatch flag |
| err_ff | output | 1 | Sticky full-field mismatch flag |
| err_pkt | output | 1 | Sticky missing or malformed packet flag |

## Verification
The clear pulse and the setting of a flag by a faulty packet can land in the same cycle. That cycle is the one in which the checksum word is sampled. The bench provokes this by clearing all flags first and then sending a packet with a corrupted active check word, with `err_clr` high together with its final word. The active flag must read 1 afterwards. A plain clear pulse on an idle cycle, by contrast, must leave every flag at 0.

// File: rtl/edh_engine.sv
module edh_engine #(
  parameter logic [15:0] POLY = 16'h1041,
  parameter logic [7:0]  DID  = 8'hF4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [9:0] vid_in,
  input  logic       in_active,
  input  logic       in_field,
  input  logic       pkt_slot,
  input  logic       edh_en,
  input  logic       edh_force,
  input  logic       err_clr,
  output logic [9:0] vid_out,
  output logic       err_ap,
  output logic       err_ff,
  output logic       err_pkt
);
  localparam int NUDW = 5;
  localparam int PLEN = NUDW + 6;
  localparam int IW   = $clog2(PLEN + 1);

  function automatic logic [9:0] fmt8(input logic [7:0] b);
    return {~(^b), ^b, b};
  endfunction

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [9:0] w);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 10; i++)
      r = {r[14:0], 1'b0} ^ (((r[15] ^ w[i]) != 1'b0) ? POLY : 16'h0000);
    return r;
  endfunction

  localparam logic [9:0]    W_DID  = fmt8(DID);
  localparam logic [9:0]    W_DC   = fmt8(8'(NUDW));
  localparam logic [IW-1:0] K_DID  = IW'(3);
  localparam logic [IW-1:0] K_DC   = IW'(4);
  localparam logic [IW-1:0] K_AP0  = IW'(5);
  localparam logic [IW-1:0] K_AP1  = IW'(6);
  localparam logic [IW-1:0] K_FF0  = IW'(7);
  localparam logic [IW-1:0] K_FF1  = IW'(8);
  localparam logic [IW-1:0] K_LUDW = IW'(PLEN - 2);
  localparam logic [IW-1:0] K_CKS  = IW'(PLEN - 1);
  localparam logic [IW-1:0] K_END  = IW'(PLEN);

  logic [IW-1:0] in_idx, o_idx;
  logic [15:0]   acc_ap, acc_ff, snap_ap, snap_ff, g_ap, g_ff;
  logic          bad_hdr, bad_ap, bad_ff, repl_r;
  logic [8:0]    rx_sum, gen_sum;
  logic [2:0]    g_flg;
  logic [9:0]    rx_exp;
  logic [9:0]    pipe [PLEN];
  logic [PLEN-1:0] spipe;
  logic [9:0]    gw [PLEN];

  wire first   = pkt_slot && (in_idx == '0);
  wire last    = pkt_slot && (in_idx == K_CKS);
  wire mism    = (vid_in != rx_exp);
  wire cks_bad = (vid_in != {~rx_sum[8], rx_sum});
  wire new_pkt = bad_hdr | cks_bad;
  wire any_err = new_pkt | bad_ap | bad_ff;
  wire slot_o  = spipe[PLEN-1];

  always_comb begin
    case (in_idx)
      IW'(1), IW'(2): rx_exp = 10'h3FF;
      K_DID:          rx_exp = W_DID;
      K_DC:           rx_exp = W_DC;
      K_AP0:          rx_exp = fmt8(snap_ap[7:0]);
      K_AP1:          rx_exp = fmt8(snap_ap[15:8]);
      K_FF0:          rx_exp = fmt8(snap_ff[7:0]);
      K_FF1:          rx_exp = fmt8(snap_ff[15:8]);
      default:        rx_exp = 10'h000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_idx <= '0;
    end else if (pkt_slot) begin
      if (in_idx != K_END) in_idx <= in_idx + 1'b1;
    end else begin
      in_idx <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_ap  <= '0;
      acc_ff  <= '0;
      snap_ap <= '0;
      snap_ff <= '0;
    end else if (first) begin
      snap_ap <= acc_ap;
      snap_ff <= acc_ff;
      acc_ap  <= '0;
      acc_ff  <= '0;
    end else if (!pkt_slot) begin
      if (in_active) acc_ap <= crc_step(acc_ap, vid_in);
      if (in_field)  acc_ff <= crc_step(acc_ff, vid_in);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bad_hdr <= 1'b0;
      bad_ap  <= 1'b0;
      bad_ff  <= 1'b0;
      rx_sum  <= '0;
    end else if (first) begin
      bad_hdr <= mism;
      bad_ap  <= 1'b0;
      bad_ff  <= 1'b0;
      rx_sum  <= '0;
    end else if (pkt_slot) begin
      if (in_idx <= K_DC)                            bad_hdr <= bad_hdr | mism;
      if (in_idx == K_AP0 || in_idx == K_AP1)        bad_ap  <= bad_ap | mism;
      if (in_idx == K_FF0 || in_idx == K_FF1)        bad_ff  <= bad_ff | mism;
      if (in_idx >= K_DID && in_idx <= K_LUDW)       rx_sum  <= rx_sum + vid_in[8:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      repl_r <= 1'b0;
      g_ap   <= '0;
      g_ff   <= '0;
      g_flg  <= '0;
    end else if (last) begin
      repl_r <= edh_force | (edh_en & any_err);
      g_ap   <= snap_ap;
      g_ff   <= snap_ff;
      g_flg  <= {new_pkt, bad_ff, bad_ap};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_ap  <= 1'b0;
      err_ff  <= 1'b0;
      err_pkt <= 1'b0;
    end else begin
      err_ap  <= (err_ap  & ~err_clr) | (last & bad_ap);
      err_ff  <= (err_ff  & ~err_clr) | (last & bad_ff);
      err_pkt <= (err_pkt & ~err_clr) | (last & new_pkt);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < PLEN; k++) pipe[k] <= '0;
      spipe <= '0;
      o_idx <= '0;
    end else begin
      pipe[0] <= vid_in;
      for (int k = 1; k < PLEN; k++) pipe[k] <= pipe[k-1];
      spipe <= {spipe[PLEN-2:0], pkt_slot};
      if (slot_o) begin
        if (o_idx != K_END) o_idx <= o_idx + 1'b1;
      end else begin
        o_idx <= '0;
      end
    end
  end

  always_comb begin
    gw[0] = 10'h000;
    gw[1] = 10'h3FF;
    gw[2] = 10'h3FF;
    gw[3] = W_DID;
    gw[4] = W_DC;
    gw[5] = fmt8(g_ap[7:0]);
    gw[6] = fmt8(g_ap[15:8]);
    gw[7] = fmt8(g_ff[7:0]);
    gw[8] = fmt8(g_ff[15:8]);
    gw[9] = fmt8({5'b0, g_flg});
    gen_sum = '0;
    for (int k = 3; k < PLEN - 1; k++) gen_sum = gen_sum + gw[k][8:0];
    gw[PLEN-1] = {~gen_sum[8], gen_sum};
  end

  assign vid_out = (slot_o && repl_r && o_idx < K_END) ? gw[o_idx] : pipe[PLEN-1];

  logic [4:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 5'd31) warm <= warm + 1'b1;
  end

  AST_DELAY_PASS: assert property (@(posedge clk) disable iff (rst)
    (warm > 5'(PLEN) && !$past(pkt_slot, PLEN)) |-> (vid_out == $past(vid_in, PLEN)))
    else $error("delay path broken"); // R6

  AST_FORCE_HEADER: assert property (@(posedge clk) disable iff (rst)
    $past(pkt_slot && in_idx == K_CKS && edh_force) |-> (vid_out == 10'h000))
    else $error("forced packet header missing"); // R7

  AST_STICKY_AP: assert property (@(posedge clk) disable iff (rst)
    $fell(err_ap) |-> $past(err_clr))
    else $error("active flag dropped without clear"); // R10

  AST_STICKY_PKT: assert property (@(posedge clk) disable iff (rst)
    $fell(err_pkt) |-> $past(err_clr))
    else $error("packet flag dropped without clear"); // R10

  AST_RESET_FLAGS: assert property (@(posedge clk)
    $past(rst) |-> (!err_ap && !err_ff && !err_pkt))
    else $error("flags not cleared by reset"); // R11
endmodule

// File: tb/tb_edh_engine.sv
module tb_edh_engine;
  localparam int CLK_PERIOD = 10;
  localparam int PLEN = 11;
  localparam int LOGN = 4096;
  typedef logic [9:0] pkt_t [PLEN];

  logic clk = 1'b0, rst = 1'b1;
  logic [9:0] vid_in = '0;
  logic in_active = 0, in_field = 0, pkt_slot = 0, edh_en = 0, edh_force = 0, err_clr = 0;
  logic [9:0] vid_out;
  logic err_ap, err_ff, err_pkt;

  always #(CLK_PERIOD/2) clk = ~clk;

  edh_engine dut (
    .clk(clk), .rst(rst), .vid_in(vid_in), .in_active(in_active), .in_field(in_field),
    .pkt_slot(pkt_slot), .edh_en(edh_en), .edh_force(edh_force), .err_clr(err_clr),
    .vid_out(vid_out), .err_ap(err_ap), .err_ff(err_ff), .err_pkt(err_pkt)
  );

  int n_chk = 0, n_fail = 0, edge_n = 0, cap = 0;
  bit done = 0;
  logic [9:0] out_log [LOGN];
  logic [15:0] m_ap = '0, m_ff = '0;
  logic [2:0] m_err = '0;
  int g_s0, g_p0;
  logic [9:0] g_pw;
  logic [15:0] g_sap, g_sff;
  pkt_t g_exp, g_rx;

  always @(posedge clk) edge_n <= edge_n + 1;
  always @(negedge clk) out_log[edge_n % LOGN] = vid_out;

  function automatic logic [9:0] fmt8(input logic [7:0] b);
    logic p;
    p = ^b;
    return {~p, p, b};
  endfunction

  function automatic logic [15:0] crc_b(input logic [15:0] c, input logic [9:0] w);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < 10; i++) begin
      fb = r[15] ^ w[i];
      r = r << 1;
      if (fb) r = r ^ 16'h1041;
    end
    return r;
  endfunction

  function automatic pkt_t make_pkt(input logic [15:0] ap, input logic [15:0] ff, input logic [7:0] fl);
    pkt_t p;
    logic [8:0] s;
    p[0] = 10'h000; p[1] = 10'h3FF; p[2] = 10'h3FF; p[3] = 10'h1F4; p[4] = 10'h205;
    p[5] = fmt8(ap[7:0]); p[6] = fmt8(ap[15:8]); p[7] = fmt8(ff[7:0]); p[8] = fmt8(ff[15:8]);
    p[9] = fmt8(fl);
    s = '0;
    for (int k = 3; k < 10; k++) s = s + p[k][8:0];
    p[10] = {~s[8], s};
    return p;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [9:0] w, input logic a, input logic f, input logic s, input logic c);
    @(negedge clk);
    vid_in = w; in_active = a; in_field = f; pkt_slot = s; err_clr = c;
    cap = edge_n + 1;
    if (!s) begin
      if (a) m_ap = crc_b(m_ap, w);
      if (f) m_ff = crc_b(m_ff, w);
    end
    if (c && !s) m_err = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(10'h040, 0, 0, 0, 0);
  endtask

  // kind: 0 good, 1 bad active word, 2 absent, 3 bad checksum, 4 good but odd status byte
  task automatic run_field(input int n, input int seed, input int kind, input bit clr_last);
    logic hdr_bad, ap_bad, ff_bad, cks_bad, rep;
    logic [8:0] s;
    logic [2:0] flg;
    for (int i = 0; i < n; i++) begin
      drive(10'((seed * 97 + i * 29 + 5) & 10'h3FF), (i % 3) != 0, 1'b1, 1'b0, 1'b0);
      if (i == 0) begin g_p0 = cap; g_pw = vid_in; end
    end
    g_sap = m_ap; g_sff = m_ff;
    m_ap = '0; m_ff = '0;
    case (kind)
      1: g_rx = make_pkt(g_sap ^ 16'h0001, g_sff, 8'h00);
      2: for (int k = 0; k < PLEN; k++) g_rx[k] = 10'h040;
      4: g_rx = make_pkt(g_sap, g_sff, 8'h80);
      default: g_rx = make_pkt(g_sap, g_sff, 8'h00);
    endcase
    if (kind == 3) g_rx[10] = g_rx[10] ^ 10'h001;
    for (int k = 0; k < PLEN; k++) begin
      drive(g_rx[k], 0, 0, 1'b1, (k == PLEN - 1) && clr_last);
      if (k == 0) g_s0 = cap;
    end
    hdr_bad = (g_rx[0] != 10'h000) || (g_rx[1] != 10'h3FF) || (g_rx[2] != 10'h3FF) ||
              (g_rx[3] != 10'h1F4) || (g_rx[4] != 10'h205);
    ap_bad = (g_rx[5] != fmt8(g_sap[7:0])) || (g_rx[6] != fmt8(g_sap[15:8]));
    ff_bad = (g_rx[7] != fmt8(g_sff[7:0])) || (g_rx[8] != fmt8(g_sff[15:8]));
    s = '0;
    for (int k = 3; k < 10; k++) s = s + g_rx[k][8:0];
    cks_bad = g_rx[10] != {~s[8], s};
    flg = {hdr_bad | cks_bad, ff_bad, ap_bad};
    rep = edh_force | (edh_en & (|flg));
    g_exp = rep ? make_pkt(g_sap, g_sff, {5'b0, flg}) : g_rx;
    m_err = clr_last ? flg : (m_err | flg);
    idle(14);
  endtask

  task automatic check_pkt();
    string tg;
    for (int i = 0; i < PLEN; i++) begin
      tg = (i < 5) ? "R3 packet head" : (i < 9) ? "R1 check word" : (i == 9) ? "R4 status word" : "R5 checksum";
      check(tg, 32'(out_log[(g_s0 + i + 10) % LOGN]), 32'(g_exp[i]));
    end
  endtask

  task automatic check_flags(input string tg);
    check(tg, {29'b0, err_pkt, err_ff, err_ap}, {29'b0, m_err});
  endtask

  task automatic t_reset();
    check("R11 reset output", 32'(vid_out), 32'h0);
    check("R11 reset flags", {29'b0, err_pkt, err_ff, err_ap}, 32'h0);
  endtask

  task automatic t_zero_chars();
    edh_force = 1; edh_en = 0;
    run_field(0, 1, 2, 0);
    check_pkt();
    check("R11 zero check word", 32'(out_log[(g_s0 + 15) % LOGN]), 32'h200);
    check("R7 forced header", 32'(out_log[(g_s0 + 13) % LOGN]), 32'h1F4);
    check_flags("R10 flags after absent");
    drive(10'h040, 0, 0, 0, 1);
    idle(2);
    m_err = '0;
    check_flags("R10 plain clear");
  endtask

  task automatic t_en_good();
    edh_force = 0; edh_en = 1;
    run_field(20, 2, 0, 0);
    check_pkt();
    for (int k = 0; k < PLEN; k++)
      check("R8 correct packet kept", 32'(out_log[(g_s0 + k + 10) % LOGN]), 32'(g_rx[k]));
    check("R6 pixel delay", 32'(out_log[(g_p0 + 10) % LOGN]), 32'(g_pw));
    check_flags("R10 no error flags");
  endtask

  task automatic t_force_status();
    edh_force = 1; edh_en = 0;
    run_field(17, 3, 4, 0);
    check_pkt();
    check("R7 status byte rewritten", 32'(out_log[(g_s0 + 19) % LOGN]), 32'(fmt8(8'h00)));
  endtask

  task automatic t_en_bad_crc();
    edh_force = 0; edh_en = 1;
    run_field(23, 4, 1, 0);
    check_pkt();
    check("R4 status active bit", 32'(out_log[(g_s0 + 19) % LOGN]), 32'(fmt8(8'h01)));
    check("R10 active flag set", 32'(err_ap), 32'h1);
    check_flags("R10 flag set");
  endtask

  task automatic t_absent();
    edh_force = 0; edh_en = 1;
    run_field(9, 5, 2, 0);
    check_pkt();
    check("R5 packet fault flag", 32'(err_pkt), 32'h1);
    check_flags("R10 flags after absent packet");
  endtask

  task automatic t_none();
    drive(10'h040, 0, 0, 0, 1);
    idle(2);
    edh_force = 0; edh_en = 0;
    run_field(12, 6, 3, 0);
    for (int k = 0; k < PLEN; k++)
      check("R9 packet untouched", 32'(out_log[(g_s0 + k + 10) % LOGN]), 32'(g_rx[k]));
    check("R9 flag still updates", 32'(err_pkt), 32'h1);
    check_flags("R10 flags with controls low");
  endtask

  task automatic t_clr_vs_set();
    drive(10'h040, 0, 0, 0, 1);
    idle(2);
    check_flags("R10 cleared before collision");
    edh_force = 0; edh_en = 1;
    run_field(15, 7, 1, 1);
    check("R10 set beats clear", 32'(err_ap), 32'h1);
    check_flags("R10 collision flags");
  endtask

  task automatic t_snapshot();
    edh_force = 1; edh_en = 0;
    run_field(30, 8, 0, 0);
    run_field(11, 9, 0, 0);
    check_pkt();
    check("R2 restart at slot", 32'(out_log[(g_s0 + 15) % LOGN]), 32'(fmt8(g_sap[7:0])));
    check("R2 full-field restart", 32'(out_log[(g_s0 + 18) % LOGN]), 32'(fmt8(g_sff[15:8])));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    t_zero_chars();
    t_en_good();
    t_force_status();
    t_en_bad_crc();
    t_absent();
    t_none();
    t_clr_vs_set();
    t_snapshot();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule